// File: doc/BRIEF.md
# Address Register Post-Modify Unit

This block keeps a small file of address registers for a datapath that walks through memory with indirect accesses. On every access the datapath names one register and an update mode. The unit presents that register's current value as the address for the access. In the same clock it computes the register's next value: unchanged, one higher, one lower, or offset by a configured signed step. The new value is written back at the clock edge. Memory itself sits outside the block.

The registers fall into two groups. The low group holds registers 0 to 3 and the high group holds registers 4 and 5. Each group has its own step and its own circular-buffer length. Every register has a separate enable bit that picks between plain 16-bit wrap-around arithmetic and circular addressing inside an aligned buffer. A direct load port writes a register from outside and wins over a post-modify of the same register in the same cycle. All register contents are visible at all times on a flat output bus.

Top module: `addr_postmod_unit`

## Requirements
- R1: After reset every register reads 0, both group steps are 0 and both modulo fields are 0, so a buffer length of 1 applies.
- R2: `acc_addr` always shows the value of the register named by `acc_sel` before any update. Register k appears on `regs_o[16k+15:16k]`.
- R3: On an access (`acc_vld`=1) to a register whose enable bit is clear, the register takes a new value at the next edge. Mode 0 keeps it unchanged, mode 1 adds 1, mode 2 subtracts 1 and mode 3 adds the group's sign-extended step. All results wrap modulo 2^16.
- R4: Registers 0 to 3 use the low-group step and modulo field. Registers 4 and 5 use the high-group ones.
- R5: A configuration write (`cfg_wr`=1) stores `cfg_step` as a 7-bit two's-complement step (-64 to 63) and `cfg_mod` as the buffer length minus one (1 to 512). It goes into the low group when `cfg_grp`=0 and into the high group when `cfg_grp`=1, and takes effect from the next cycle.
- R6: With the register's bit in `mod_en` set, the mask is all ones up to the highest set bit of the modulo field. The base is the register with its mask bits cleared and the offset is the register with its mask bits kept. Incrementing from offset length-1 returns to the base.
- R7: In circular mode, decrementing at offset 0 moves to offset length-1, with the base kept.
- R8: In circular mode the step is added to the offset. A negative sum gets the length added once, and a sum at or above the length gets the length subtracted once. The result is masked and combined with the unchanged base. Mode 0 leaves the register untouched.
- R9: A load (`ld_vld`=1) writes `ld_data` into register `ld_sel` at the next edge. It overrides an access to the same register in that cycle.
- R10: Only the accessed register and the loaded register change. With `acc_vld`=0 the mode and select inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_vld | input | 1 | Access strobe |
| acc_sel | input | 3 | Register used by the access |
| acc_mode | input | 2 | Update mode: 0 hold, 1 increment, 2 decrement, 3 step |
| acc_addr | output | 16 | Pre-update address of the selected register |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_grp | input | 1 | Group written: 0 low, 1 high |
| cfg_step | input | 7 | Signed step value |
| cfg_mod | input | 9 | Buffer length minus one |
| mod_en | input | 6 | Per-register circular-mode enable |
| ld_vld | input | 1 | Direct load strobe |
| ld_sel | input | 3 | Register loaded |
| ld_data | input | 16 | Load value |
| regs_o | output | 96 | All register contents, register k in bits 16k+15:16k |

## Verification
Linear walks are started next to 0xFFFF and 0x0000 so that wrap-around cannot be confused with saturation. Positive and negative steps are placed in the two groups to show each register reads the correct group. Circular runs use a non-power-of-two length of 10 and the full length of 512, entering from both ends and stepping over each edge, which separates the mask, base and correction terms. A long pseudo-random mix of accesses, loads, same-register collisions and configuration changes is then compared every cycle against a behavioural model.

// File: rtl/arpm_pkg.sv
package arpm_pkg;

   typedef enum logic [1:0] {
      PM_HOLD = 2'd0,
      PM_INC  = 2'd1,
      PM_DEC  = 2'd2,
      PM_STEP = 2'd3
   } pm_mode_e;

endpackage

// File: rtl/arpm_cfg_bank.sv
module arpm_cfg_bank #(
   parameter int NUM_GRP = 2,
   parameter int STEP_W  = 7,
   parameter int MOD_W   = 9,
   localparam int GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [GSEL_W-1:0]           wr_grp,
   input  logic [STEP_W-1:0]           wr_step,
   input  logic [MOD_W-1:0]            wr_mod,
   output logic [NUM_GRP*STEP_W-1:0]   step_flat,
   output logic [NUM_GRP*MOD_W-1:0]    mod_flat
);

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [STEP_W-1:0] step_q;
      logic [MOD_W-1:0]  mod_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            step_q <= '0;
            mod_q  <= '0;
         end else if (wr && (wr_grp == GSEL_W'(g))) begin
            step_q <= wr_step;
            mod_q  <= wr_mod;
         end
      end

      assign step_flat[g*STEP_W +: STEP_W] = step_q;
      assign mod_flat[g*MOD_W +: MOD_W]    = mod_q;
   end

endmodule

// File: rtl/arpm_mask_gen.sv
module arpm_mask_gen #(
   parameter int MOD_W = 9
) (
   input  logic [MOD_W-1:0] len_m1,
   output logic [MOD_W-1:0] mask
);

   // bit b of the mask is set when any bit at or above b is set
   always_comb begin
      for (int b = 0; b < MOD_W; b++) begin
         mask[b] = |(len_m1 >> b);
      end
   end

endmodule

// File: rtl/arpm_next.sv
module arpm_next
   import arpm_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int STEP_W    = 7,
   parameter int MOD_W     = 9,
   parameter bit MODULO_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [1:0]        mode,
   input  logic [STEP_W-1:0] step,
   input  logic [MOD_W-1:0]  len_m1,
   input  logic              circ,
   output logic [ADDR_W-1:0] nxt
);

   localparam int OFF_W = MOD_W + 2;

   pm_mode_e          mode_e;
   logic [ADDR_W-1:0] lin_delta;
   logic [ADDR_W-1:0] lin_nxt;

   assign mode_e = pm_mode_e'(mode);

   always_comb begin
      unique case (mode_e)
         PM_INC:  lin_delta = ADDR_W'(1);
         PM_DEC:  lin_delta = '1;
         PM_STEP: lin_delta = {{(ADDR_W-STEP_W){step[STEP_W-1]}}, step};
         default: lin_delta = '0;
      endcase
   end

   assign lin_nxt = cur + lin_delta;

   if (MODULO_EN) begin : g_circ
      logic [MOD_W-1:0]        mask;
      logic [MOD_W-1:0]        off;
      logic signed [OFF_W-1:0] delta;
      logic signed [OFF_W-1:0] len;
      logic signed [OFF_W-1:0] sum;
      logic signed [OFF_W-1:0] fixed;
      logic [ADDR_W-1:0]       circ_nxt;

      arpm_mask_gen #(.MOD_W(MOD_W)) i_mask (
         .len_m1 (len_m1),
         .mask   (mask)
      );

      assign off   = cur[MOD_W-1:0] & mask;
      assign delta = $signed(lin_delta[OFF_W-1:0]);
      assign len   = $signed({2'b00, len_m1}) + $signed(OFF_W'(1));
      assign sum   = $signed({2'b00, off}) + delta;

      always_comb begin
         if (sum < 0) begin
            fixed = sum + len;
         end else if (sum >= len) begin
            fixed = sum - len;
         end else begin
            fixed = sum;
         end
      end

      assign circ_nxt = (cur & ~ADDR_W'(mask)) | ADDR_W'(fixed[MOD_W-1:0] & mask);

      always_comb begin
         if (mode_e == PM_HOLD) begin
            nxt = cur;
         end else if (circ) begin
            nxt = circ_nxt;
         end else begin
            nxt = lin_nxt;
         end
      end
   end else begin : g_lin
      assign nxt = lin_nxt;
   end

endmodule

// File: rtl/addr_postmod_unit.sv
module addr_postmod_unit #(
   parameter int NUM_REGS     = 6,
   parameter int LOW_GRP_REGS = 4,
   parameter int ADDR_W       = 16,
   parameter int STEP_W       = 7,
   parameter int MOD_W        = 9,
   parameter bit MODULO_EN    = 1'b1,
   localparam int SEL_W       = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_vld,
   input  logic [SEL_W-1:0]           acc_sel,
   input  logic [1:0]                 acc_mode,
   output logic [ADDR_W-1:0]          acc_addr,
   input  logic                       cfg_wr,
   input  logic                       cfg_grp,
   input  logic [STEP_W-1:0]          cfg_step,
   input  logic [MOD_W-1:0]           cfg_mod,
   input  logic [NUM_REGS-1:0]        mod_en,
   input  logic                       ld_vld,
   input  logic [SEL_W-1:0]           ld_sel,
   input  logic [ADDR_W-1:0]          ld_data,
   output logic [NUM_REGS*ADDR_W-1:0] regs_o
);

   localparam int NUM_GRP = 2;

   if (NUM_REGS < 2) begin : g_chk_regs
      $error("NUM_REGS must be at least 2");
   end
   if (LOW_GRP_REGS < 1 || LOW_GRP_REGS >= NUM_REGS) begin : g_chk_split
      $error("LOW_GRP_REGS must leave both groups non-empty");
   end
   if (STEP_W < 2 || ADDR_W <= STEP_W) begin : g_chk_step
      $error("STEP_W must be at least 2 and narrower than ADDR_W");
   end
   if (ADDR_W < MOD_W || MOD_W + 2 <= STEP_W) begin : g_chk_mod
      $error("MOD_W must fit in ADDR_W and hold the step range");
   end

   logic [NUM_GRP*STEP_W-1:0] step_flat;
   logic [NUM_GRP*MOD_W-1:0]  mod_flat;
   logic                      sel_ok;
   logic                      sel_hi;
   logic [ADDR_W-1:0]         cur;
   logic [STEP_W-1:0]         cur_step;
   logic [MOD_W-1:0]          cur_len_m1;
   logic                      cur_circ;
   logic [ADDR_W-1:0]         nxt;

   arpm_cfg_bank #(
      .NUM_GRP (NUM_GRP),
      .STEP_W  (STEP_W),
      .MOD_W   (MOD_W)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wr_grp    (cfg_grp),
      .wr_step   (cfg_step),
      .wr_mod    (cfg_mod),
      .step_flat (step_flat),
      .mod_flat  (mod_flat)
   );

   assign sel_ok     = (acc_sel < SEL_W'(NUM_REGS));
   assign sel_hi     = (acc_sel >= SEL_W'(LOW_GRP_REGS));
   assign cur        = sel_ok ? regs_o[acc_sel*ADDR_W +: ADDR_W] : '0;
   assign cur_circ   = sel_ok ? mod_en[acc_sel] : 1'b0;
   assign cur_step   = sel_hi ? step_flat[STEP_W +: STEP_W] : step_flat[0 +: STEP_W];
   assign cur_len_m1 = sel_hi ? mod_flat[MOD_W +: MOD_W] : mod_flat[0 +: MOD_W];
   assign acc_addr   = cur;

   arpm_next #(
      .ADDR_W    (ADDR_W),
      .STEP_W    (STEP_W),
      .MOD_W     (MOD_W),
      .MODULO_EN (MODULO_EN)
   ) i_next (
      .cur    (cur),
      .mode   (acc_mode),
      .step   (cur_step),
      .len_m1 (cur_len_m1),
      .circ   (cur_circ),
      .nxt    (nxt)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [ADDR_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (ld_vld && (ld_sel == SEL_W'(i))) begin
            q <= ld_data;
         end else if (acc_vld && (acc_sel == SEL_W'(i))) begin
            q <= nxt;
         end
      end

      assign regs_o[i*ADDR_W +: ADDR_W] = q;
   end

endmodule

// File: rtl/addr_postmod_unit_chk.sv
module addr_postmod_unit_chk #(
   parameter int NUM_REGS = 6,
   parameter int ADDR_W   = 16,
   parameter int SEL_W    = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       acc_vld,
   input logic [SEL_W-1:0]           acc_sel,
   input logic [1:0]                 acc_mode,
   input logic [ADDR_W-1:0]          acc_addr,
   input logic [NUM_REGS-1:0]        mod_en,
   input logic                       ld_vld,
   input logic [SEL_W-1:0]           ld_sel,
   input logic [ADDR_W-1:0]          ld_data,
   input logic [NUM_REGS*ADDR_W-1:0] regs_o
);

   logic [ADDR_W-1:0] r_arr [NUM_REGS];
   logic [SEL_W-1:0]  p_ld_sel;
   logic [ADDR_W-1:0] p_ld_data;
   logic [SEL_W-1:0]  p_acc_sel;
   logic [ADDR_W-1:0] p_acc_addr;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_unpack
      assign r_arr[i] = regs_o[i*ADDR_W +: ADDR_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_ld_sel   <= '0;
         p_ld_data  <= '0;
         p_acc_sel  <= '0;
         p_acc_addr <= '0;
      end else begin
         p_ld_sel   <= ld_sel;
         p_ld_data  <= ld_data;
         p_acc_sel  <= acc_sel;
         p_acc_addr <= acc_addr;
      end
   end

   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld |-> acc_sel < SEL_W'(NUM_REGS)) and (ld_vld |-> ld_sel < SEL_W'(NUM_REGS))); // R2

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vld |=> r_arr[p_ld_sel] == p_ld_data); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_vld && !ld_vld) |=> $stable(regs_o)); // R10

   AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_mode == 2'd0 && !ld_vld) |=> $stable(regs_o)); // R3

   AST_INC_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_mode == 2'd1 && !mod_en[acc_sel] && !ld_vld)
      |=> r_arr[p_acc_sel] == p_acc_addr + ADDR_W'(1)); // R3

   AST_DEC_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_mode == 2'd2 && !mod_en[acc_sel] && !ld_vld)
      |=> r_arr[p_acc_sel] == p_acc_addr - ADDR_W'(1)); // R3

endmodule

bind addr_postmod_unit addr_postmod_unit_chk #(
   .NUM_REGS (NUM_REGS),
   .ADDR_W   (ADDR_W),
   .SEL_W    (SEL_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_vld  (acc_vld),
   .acc_sel  (acc_sel),
   .acc_mode (acc_mode),
   .acc_addr (acc_addr),
   .mod_en   (mod_en),
   .ld_vld   (ld_vld),
   .ld_sel   (ld_sel),
   .ld_data  (ld_data),
   .regs_o   (regs_o)
);

// File: tb/test_addr_postmod_unit.sv
module test_addr_postmod_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NR         = 6;
   localparam int WD_LIMIT   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0;
   logic [2:0]  acc_sel = '0;
   logic [1:0]  acc_mode = '0;
   logic [15:0] acc_addr;
   logic        cfg_wr = 1'b0;
   logic        cfg_grp = 1'b0;
   logic [6:0]  cfg_step = '0;
   logic [8:0]  cfg_mod = '0;
   logic [5:0]  mod_en = '0;
   logic        ld_vld = 1'b0;
   logic [2:0]  ld_sel = '0;
   logic [15:0] ld_data = '0;
   logic [95:0] regs_o;

   int    n_run = 0;
   int    n_fail = 0;
   int    cyc = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   int mdl [NR];
   int m_step [2];
   int m_len_m1 [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_postmod_unit i_addr_postmod_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_vld  (acc_vld),
      .acc_sel  (acc_sel),
      .acc_mode (acc_mode),
      .acc_addr (acc_addr),
      .cfg_wr   (cfg_wr),
      .cfg_grp  (cfg_grp),
      .cfg_step (cfg_step),
      .cfg_mod  (cfg_mod),
      .mod_en   (mod_en),
      .ld_vld   (ld_vld),
      .ld_sel   (ld_sel),
      .ld_data  (ld_data),
      .regs_o   (regs_o)
   );

   function automatic int ref_next(int cur, int mode, int step, int len_m1, bit circ);
      int d, len, p, mask, off, base, s;
      if (mode == 0) return cur;
      d = (mode == 1) ? 1 : (mode == 2) ? -1 : step;
      if (!circ) return (cur + d) & 32'hFFFF;
      len = len_m1 + 1;
      p = 1;
      while (p < len) p = p * 2;
      mask = p - 1;
      off  = cur & mask;
      base = cur - off;
      s    = off + d;
      if (s < 0) s = s + len;
      else if (s >= len) s = s - len;
      return base + (s & mask);
   endfunction

   // behavioural reference, updated at the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NR; k++) mdl[k] = 0;
         for (int g = 0; g < 2; g++) begin
            m_step[g] = 0;
            m_len_m1[g] = 0;
         end
      end else begin
         int g, sv;
         if (acc_vld && !(ld_vld && ld_sel == acc_sel)) begin
            g = (acc_sel >= 4) ? 1 : 0;
            mdl[acc_sel] = ref_next(mdl[acc_sel], int'(acc_mode), m_step[g],
                                    m_len_m1[g], mod_en[acc_sel]);
         end
         if (ld_vld) mdl[ld_sel] = int'(ld_data);
         if (cfg_wr) begin
            sv = int'(cfg_step);
            if (sv >= 64) sv = sv - 128;
            m_step[cfg_grp] = sv;
            m_len_m1[cfg_grp] = int'(cfg_mod);
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on && !done) begin
         logic [95:0] exp_regs;
         logic [15:0] exp_addr;
         for (int k = 0; k < NR; k++) exp_regs[k*16 +: 16] = 16'(mdl[k]);
         exp_addr = (acc_sel < 3'(NR)) ? 16'(mdl[acc_sel]) : 16'h0;
         n_run++;
         if (regs_o !== exp_regs || acc_addr !== exp_addr) begin
            n_fail++;
            $display("FAIL %s: regs act=%h exp=%h addr act=%h exp=%h",
                     cur_req, regs_o, exp_regs, acc_addr, exp_addr);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic op(input bit av, input int as, input int am,
                     input bit lv, input int ls, input int ldv);
      @(posedge clk);
      #1;
      cfg_wr   = 1'b0;
      acc_vld  = av;
      acc_sel  = 3'(as);
      acc_mode = 2'(am);
      ld_vld   = lv;
      ld_sel   = 3'(ls);
      ld_data  = 16'(ldv);
   endtask

   task automatic cfg(input int g, input int st, input int lm1);
      @(posedge clk);
      #1;
      acc_vld  = 1'b0;
      ld_vld   = 1'b0;
      cfg_wr   = 1'b1;
      cfg_grp  = g[0];
      cfg_step = 7'(st);
      cfg_mod  = 9'(lm1);
   endtask

   task automatic load(input int r, input int v);
      op(1'b0, 0, 0, 1'b1, r, v);
   endtask

   initial begin
      logic [15:0] lfsr;
      repeat (2) @(posedge clk);
      #1;
      chk_on = 1'b1;
      cur_req = "R1";
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      op(1'b1, 0, 3, 1'b0, 0, 0);           // R1 zero step after reset
      op(1'b1, 4, 3, 1'b0, 0, 0);

      cur_req = "R9";
      load(0, 16'hFFFF);
      load(1, 16'h1238);
      load(2, 16'h0000);
      load(3, 16'h8000);
      load(4, 16'h05FE);
      load(5, 16'h1000);

      cur_req = "R3";
      op(1'b1, 0, 1, 1'b0, 0, 0);           // FFFF -> 0000
      op(1'b1, 2, 2, 1'b0, 0, 0);           // 0000 -> FFFF
      op(1'b1, 3, 0, 1'b0, 0, 0);           // hold
      cur_req = "R2";
      op(1'b1, 5, 0, 1'b0, 0, 0);

      cur_req = "R5";
      cfg(0, -5, 9);
      cfg(1, 17, 511);
      cur_req = "R4";
      op(1'b1, 3, 3, 1'b0, 0, 0);           // 8000 - 5
      op(1'b1, 5, 3, 1'b0, 0, 0);           // 1000 + 17

      cur_req = "R6";
      op(1'b0, 0, 0, 1'b0, 0, 0);
      mod_en = 6'b010010;
      op(1'b1, 1, 1, 1'b0, 0, 0);           // 1238 -> 1239
      op(1'b1, 1, 1, 1'b0, 0, 0);           // 1239 -> 1230
      op(1'b1, 4, 1, 1'b0, 0, 0);           // 05FE -> 05FF
      op(1'b1, 4, 1, 1'b0, 0, 0);           // 05FF -> 0400
      cur_req = "R7";
      op(1'b1, 1, 2, 1'b0, 0, 0);           // 1230 -> 1239
      cur_req = "R8";
      load(1, 16'h1232);
      op(1'b1, 1, 3, 1'b0, 0, 0);           // -> 1237
      op(1'b1, 1, 0, 1'b0, 0, 0);           // hold in circular mode
      op(1'b1, 4, 3, 1'b0, 0, 0);           // 0400 -> 0411
      load(4, 16'h05F8);
      op(1'b1, 4, 3, 1'b0, 0, 0);           // -> 0409

      cur_req = "R9";
      op(1'b1, 2, 1, 1'b1, 2, 16'hABCD);    // load wins
      cur_req = "R10";
      op(1'b1, 0, 1, 1'b1, 5, 16'h7777);    // both registers move
      op(1'b0, 3, 1, 1'b0, 0, 0);           // strobe low: nothing moves
      op(1'b0, 1, 3, 1'b0, 0, 0);

      cur_req = "mixed";
      lfsr = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 4'd0) begin
            cfg(int'(lfsr[4]), int'(lfsr[11:5]), int'(lfsr[15:10]) % 40);
         end else begin
            if (lfsr[7:4] == 4'd1) mod_en = lfsr[13:8];
            op(lfsr[0] | lfsr[1], int'(lfsr[10:8]) % NR, int'(lfsr[12:11]),
               lfsr[15:13] == 3'd0, int'(lfsr[6:4]) % NR, int'(lfsr ^ 16'h5A5A));
         end
      end
      op(1'b0, 0, 0, 1'b0, 0, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule